// File: doc/BRIEF.md
# Command-Acknowledge Bus Transfer Sequencer

This block is the master-side controller of a bus with a single master. It runs one peripheral transfer at a time as a fixed exchange in four phases. First it drives a command to the target device. Then it waits for the device to acknowledge. Next it accepts the requested number of data words. Last it waits for the device to confirm completion. It takes no new request until that confirmation has arrived, so two transfers can never collide on the bus.

A host starts a transfer with a one-cycle start strobe that carries a command code, an address and a word count. It then watches `busy` and receives a `done` or `error` pulse at the end. Every waiting phase is guarded by a cycle timeout that the host programs. A missing acknowledge, a stalled data phase or a missing confirmation ends the transfer with an error. A wrong beat count also ends it with an error.

Top module: `cmd_ack_xfer_seq`

## Requirements
- R1: After reset `busy`, `done`, `error` and `bus_cmd_valid` are low. A `req_start` seen while `busy` is low raises `bus_cmd_valid` for exactly one cycle, in the next cycle. During that cycle `bus_cmd`, `bus_addr` and `bus_len` carry the request, and `busy` is high.
- R2: `req_start` while `busy` is high is ignored: no second command is issued and the running transfer finishes normally.
- R3: Data beats (`bus_data_valid`) presented before the acknowledge are not taken. `bus_ack` is honoured only while the sequencer is waiting for it.
- R4: Every accepted beat appears on `xfer_word_valid`/`xfer_word` one cycle later, in arrival order.
- R5: When `bus_complete` arrives after exactly `req_len` beats, `done` pulses for one cycle with `busy` low. The number of busy cycles is 3 + len + (cycles waited for ack) + (idle cycles between beats) + (cycles waited for completion).
- R6: A `bus_complete` before all requested beats have arrived is a protocol error.
- R7: A beat after the requested count, before the completion, is a protocol error and is not taken.
- R8: Each wait (for the acknowledge, for each next beat, for the completion) may last at most `tmo_limit` cycles. An event in the last allowed cycle is accepted. Otherwise the transfer ends in error. A `tmo_limit` of 0 behaves as 1.
- R9: On any error, `error` pulses for one cycle while `busy` is still high. `busy` falls in the next cycle. No `done` is given for that transfer, and a new request is then accepted.
- R10: A request with `req_len` of 0 spends one data-phase cycle with no beat. The completion must come after that cycle. A beat or a completion in that cycle is an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Host start strobe |
| req_cmd | input | CMD_W | Command code for the transfer |
| req_addr | input | ADDR_W | Target address |
| req_len | input | LEN_W | Number of data words expected |
| tmo_limit | input | TMO_W | Maximum cycles for each wait |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| error | output | 1 | One-cycle pulse on timeout or protocol error |
| bus_cmd_valid | output | 1 | Command strobe to the device |
| bus_cmd | output | CMD_W | Command code on the bus |
| bus_addr | output | ADDR_W | Address on the bus |
| bus_len | output | LEN_W | Word count on the bus |
| bus_ack | input | 1 | Device acknowledge |
| bus_data_valid | input | 1 | Device data beat strobe |
| bus_data | input | DATA_W | Device data word |
| bus_complete | input | 1 | Device completion confirmation |
| xfer_word_valid | output | 1 | Captured word valid |
| xfer_word | output | DATA_W | Captured word |

## Verification
A table of device responses is walked first. It varies the acknowledge delay, the beat count against the requested length, and the completion delay. Its rows separate a clean transfer from a short count, an extra beat, and timeouts that hit exactly at the limit or one cycle past it. Directed cases then check the following:
- beats presented before the acknowledge are dropped;
- a start strobe during a transfer is ignored;
- a gap between beats counts against the timeout;
- a zero limit acts as one cycle.

The exact busy-cycle counts confirm the cycles spent on the command, acknowledge and completion phases.

// File: rtl/bxs_pkg.sv
package bxs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_CMD       = 3'd1,
        ST_WAIT_ACK  = 3'd2,
        ST_XFER      = 3'd3,
        ST_WAIT_DONE = 3'd4,
        ST_ERROR     = 3'd5
    } bxs_state_e;

    // States in which the phase timer runs.
    function automatic logic is_wait_state(bxs_state_e s);
        return (s == ST_WAIT_ACK) || (s == ST_XFER) || (s == ST_WAIT_DONE);
    endfunction

endpackage

// File: rtl/bxs_phase_timer.sv
module bxs_phase_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    localparam logic [TMO_W-1:0] CNT_MAX = '1;

    logic [TMO_W-1:0] cnt_d, cnt_q;

    // Current cycle is the last allowed one when cnt+1 reaches the limit.
    assign expired = run && (({1'b0, cnt_q} + (TMO_W+1)'(1)) >= {1'b0, limit});

    always_comb begin
        cnt_d = cnt_q;
        if (!run || restart) begin
            cnt_d = '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + TMO_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/bxs_beat_counter.sv
module bxs_beat_counter #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             take,
    output logic [LEN_W-1:0] count
);
    logic [LEN_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)     cnt_d = '0;
        else if (take) cnt_d = cnt_q + LEN_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/bxs_word_capture.sv
module bxs_word_capture #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] word_in,
    output logic              word_valid,
    output logic [DATA_W-1:0] word_out
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] dat;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = take;
        if (take) cap_d.dat = word_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign word_valid = cap_q.vld;
    assign word_out   = cap_q.dat;
endmodule

// File: rtl/cmd_ack_xfer_seq.sv
module cmd_ack_xfer_seq
    import bxs_pkg::*;
#(
    parameter int CMD_W  = 4,
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8,
    parameter int DATA_W = 32,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [TMO_W-1:0]  tmo_limit,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              bus_cmd_valid,
    output logic [CMD_W-1:0]  bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [LEN_W-1:0]  bus_len,
    input  logic              bus_ack,
    input  logic              bus_data_valid,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_complete,
    output logic              xfer_word_valid,
    output logic [DATA_W-1:0] xfer_word
);
    localparam int CNT_W = LEN_W + 1;

    typedef struct packed {
        bxs_state_e        state;
        logic [CMD_W-1:0]  cmd;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              done;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             beat_take;
    logic             beat_clear;
    logic             tmo_hit;
    logic             tmo_restart;
    logic [LEN_W-1:0] beats;
    logic             all_beats;
    logic             last_beat;

    assign all_beats = (beats == ctl_q.len);
    assign last_beat = (({1'b0, beats} + CNT_W'(1)) == {1'b0, ctl_q.len});

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        beat_take  = 1'b0;
        beat_clear = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_start) begin
                    ctl_d.state = ST_CMD;
                    ctl_d.cmd   = req_cmd;
                    ctl_d.addr  = req_addr;
                    ctl_d.len   = req_len;
                    beat_clear  = 1'b1;
                end
            end
            ST_CMD: ctl_d.state = ST_WAIT_ACK;
            ST_WAIT_ACK: begin
                if (bus_ack)      ctl_d.state = ST_XFER;
                else if (tmo_hit) ctl_d.state = ST_ERROR;
            end
            ST_XFER: begin
                if (bus_complete) begin
                    ctl_d.state = ST_ERROR;            // short count
                end else if (bus_data_valid) begin
                    if (all_beats) begin
                        ctl_d.state = ST_ERROR;        // zero-length overrun
                    end else begin
                        beat_take = 1'b1;
                        if (last_beat) ctl_d.state = ST_WAIT_DONE;
                    end
                end else if (all_beats) begin
                    ctl_d.state = ST_WAIT_DONE;        // empty data phase
                end else if (tmo_hit) begin
                    ctl_d.state = ST_ERROR;
                end
            end
            ST_WAIT_DONE: begin
                if (bus_data_valid) begin
                    ctl_d.state = ST_ERROR;            // extra beat
                end else if (bus_complete) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.done  = 1'b1;
                end else if (tmo_hit) begin
                    ctl_d.state = ST_ERROR;
                end
            end
            ST_ERROR: ctl_d.state = ST_IDLE;
            default:  ctl_d.state = ST_IDLE;
        endcase
        tmo_restart = (ctl_d.state != ctl_q.state) || beat_take;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    bxs_phase_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (is_wait_state(ctl_q.state)),
        .restart (tmo_restart),
        .limit   (tmo_limit),
        .expired (tmo_hit)
    );

    bxs_beat_counter #(.LEN_W(LEN_W)) u_beats (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (beat_clear),
        .take  (beat_take),
        .count (beats)
    );

    bxs_word_capture #(.DATA_W(DATA_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (beat_take),
        .word_in    (bus_data),
        .word_valid (xfer_word_valid),
        .word_out   (xfer_word)
    );

    assign busy          = (ctl_q.state != ST_IDLE);
    assign done          = ctl_q.done;
    assign error         = (ctl_q.state == ST_ERROR);
    assign bus_cmd_valid = (ctl_q.state == ST_CMD);
    assign bus_cmd       = ctl_q.cmd;
    assign bus_addr      = ctl_q.addr;
    assign bus_len       = ctl_q.len;
endmodule

// File: rtl/bxs_checker.sv
module bxs_checker (
    input logic clk,
    input logic rst_n,
    input logic req_start,
    input logic busy,
    input logic done,
    input logic error,
    input logic bus_cmd_valid,
    input logic xfer_word_valid
);
    assert_start_issues_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_start) |=> (bus_cmd_valid && busy));

    assert_cmd_single_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_valid |=> !bus_cmd_valid);

    assert_cmd_only_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_valid |-> $past(!busy));

    assert_word_not_with_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_word_valid |-> (!bus_cmd_valid && $past(busy)));

    assert_done_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !error));

    assert_error_then_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> busy ##1 (!busy && !done));
endmodule

bind cmd_ack_xfer_seq bxs_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_start       (req_start),
    .busy            (busy),
    .done            (done),
    .error           (error),
    .bus_cmd_valid   (bus_cmd_valid),
    .xfer_word_valid (xfer_word_valid)
);

// File: tb/cmd_ack_xfer_seq_tb.sv
`timescale 1ns/1ps
module cmd_ack_xfer_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic [3:0]  req_cmd = '0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic [15:0] tmo_limit = 16'd8;
    logic        busy, done, error, bus_cmd_valid;
    logic [3:0]  bus_cmd;
    logic [15:0] bus_addr;
    logic [7:0]  bus_len;
    logic        bus_ack = 1'b0;
    logic        bus_data_valid = 1'b0;
    logic [31:0] bus_data = '0;
    logic        bus_complete = 1'b0;
    logic        xfer_word_valid;
    logic [31:0] xfer_word;

    always #4 clk = ~clk;   // 125 MHz

    cmd_ack_xfer_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_len(req_len), .tmo_limit(tmo_limit),
        .busy(busy), .done(done), .error(error), .bus_cmd_valid(bus_cmd_valid),
        .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_len(bus_len),
        .bus_ack(bus_ack), .bus_data_valid(bus_data_valid), .bus_data(bus_data),
        .bus_complete(bus_complete), .xfer_word_valid(xfer_word_valid),
        .xfer_word(xfer_word)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Port monitor
    int     mon_done = 0, mon_err = 0, mon_words = 0, mon_busy = 0, mon_cmds = 0;
    int     word_base = 0;
    logic [15:0] word_tag = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done)          mon_done++;
            if (error)         mon_err++;
            if (busy)          mon_busy++;
            if (bus_cmd_valid) mon_cmds++;
            if (xfer_word_valid) begin
                chk(xfer_word == {word_tag, 16'(mon_words - word_base)}, "R4",
                    "captured word", xfer_word, {word_tag, 16'(mon_words - word_base)});
                mon_words++;
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Device model: one full exchange, returns observed deltas.
    task automatic run_xfer(input logic [3:0] c, input logic [15:0] a, input int len,
                            input int ack_dly, input int nbeats, input int gap,
                            input int cpl_dly, input int pre_beats, input bit hold_start,
                            output int b, output int dn, output int er, output int wd,
                            output int cm);
        int b0 = mon_busy, d0 = mon_done, e0 = mon_err, w0 = mon_words, c0 = mon_cmds;
        word_base = mon_words;
        req_cmd = c; req_addr = a; req_len = 8'(len); req_start = 1'b1;
        tick();
        if (!hold_start) req_start = 1'b0;
        else begin req_cmd = ~c; req_addr = ~a; end
        chk(bus_cmd_valid && busy, "R1", "cmd strobe", {busy, bus_cmd_valid}, 3);
        chk(bus_cmd == c && bus_addr == a && bus_len == 8'(len), "R1", "cmd fields",
            {bus_cmd, bus_addr}, {c, a});
        tick();
        for (int i = 0; i < ack_dly; i++) begin
            if (i < pre_beats) begin bus_data_valid = 1'b1; bus_data = 32'hDEAD_0000 + 32'(i); end
            else bus_data_valid = 1'b0;
            tick();
        end
        bus_data_valid = 1'b0;
        bus_ack = 1'b1; tick(); bus_ack = 1'b0;
        for (int i = 0; i < nbeats; i++) begin
            if (i == 1) repeat (gap) tick();
            bus_data_valid = 1'b1; bus_data = {word_tag, 16'(i)};
            tick();
            bus_data_valid = 1'b0;
        end
        req_start = 1'b0;
        repeat (cpl_dly) tick();
        bus_complete = 1'b1; tick(); bus_complete = 1'b0;
        for (int k = 0; k < 60 && busy; k++) tick();
        tick(); tick();
        b = mon_busy - b0; dn = mon_done - d0; er = mon_err - e0;
        wd = mon_words - w0; cm = mon_cmds - c0;
    endtask

    typedef struct packed {
        logic [7:0] len;
        logic [7:0] ack;
        logic [7:0] nb;
        logic [7:0] cpl;
        logic       ok;
        logic [7:0] words;
        logic [7:0] busy;
    } vec_t;

    // tmo_limit = 8 for all rows
    localparam vec_t VECS [9] = '{
        '{8'd4, 8'd0, 8'd4, 8'd0, 1'b1, 8'd4, 8'd7 },   // R5 clean burst
        '{8'd1, 8'd3, 8'd1, 8'd5, 1'b1, 8'd1, 8'd12},   // R5 with waits
        '{8'd3, 8'd7, 8'd3, 8'd7, 1'b1, 8'd3, 8'd20},   // R8 events on last allowed cycle
        '{8'd3, 8'd8, 8'd3, 8'd0, 1'b0, 8'd0, 8'd10},   // R8 ack timeout
        '{8'd3, 8'd0, 8'd2, 8'd0, 1'b0, 8'd2, 8'd6 },   // R6 short count
        '{8'd2, 8'd0, 8'd3, 8'd0, 1'b0, 8'd2, 8'd6 },   // R7 extra beat
        '{8'd2, 8'd0, 8'd2, 8'd8, 1'b0, 8'd2, 8'd13},   // R8 completion timeout
        '{8'd0, 8'd0, 8'd0, 8'd1, 1'b1, 8'd0, 8'd4 },   // R10 zero length
        '{8'd0, 8'd0, 8'd0, 8'd0, 1'b0, 8'd0, 8'd4 }    // R10 early completion
    };

    initial begin
        int b, dn, er, wd, cm;
        repeat (3) tick();
        chk(!busy && !done && !error && !bus_cmd_valid, "R1", "reset state",
            {busy, done, error, bus_cmd_valid}, 0);
        rst_n = 1'b1;
        tick();

        for (int i = 0; i < 9; i++) begin
            vec_t v;
            v = VECS[i];
            word_tag = 16'(16'h100 + i);
            run_xfer(4'(i + 1), 16'(16'h4000 + i * 3), int'(v.len), int'(v.ack), int'(v.nb),
                     0, int'(v.cpl), 0, 1'b0, b, dn, er, wd, cm);
            chk(dn == int'(v.ok), "R5", $sformatf("row %0d done count", i), dn, v.ok);
            chk(er == int'(!v.ok), "R9", $sformatf("row %0d error count", i), er, !v.ok);
            chk(wd == int'(v.words), "R4", $sformatf("row %0d words", i), wd, v.words);
            chk(b == int'(v.busy), "R5", $sformatf("row %0d busy cycles", i), b, v.busy);
        end

        // R3: beats before the acknowledge are dropped
        word_tag = 16'h0200;
        run_xfer(4'hA, 16'h1234, 2, 3, 2, 0, 0, 3, 1'b0, b, dn, er, wd, cm);
        chk(wd == 2 && dn == 1 && er == 0, "R3", "pre-ack beats dropped", wd, 2);

        // R2: start held during transfer is ignored
        word_tag = 16'h0300;
        run_xfer(4'h5, 16'h0F0F, 2, 1, 2, 0, 1, 0, 1'b1, b, dn, er, wd, cm);
        chk(cm == 1, "R2", "single command", cm, 1);
        chk(dn == 1 && wd == 2, "R2", "transfer unaffected", dn, 1);

        // R8: gap between beats within and beyond the limit
        word_tag = 16'h0400;
        run_xfer(4'h3, 16'h0001, 2, 0, 2, 7, 0, 0, 1'b0, b, dn, er, wd, cm);
        chk(dn == 1 && er == 0 && b == 12, "R8", "beat gap at limit", b, 12);
        word_tag = 16'h0500;
        run_xfer(4'h3, 16'h0002, 2, 0, 2, 8, 0, 0, 1'b0, b, dn, er, wd, cm);
        chk(er == 1 && dn == 0 && wd == 1, "R8", "beat gap timeout", er, 1);

        // R8: zero limit acts as one cycle
        tmo_limit = 16'd0;
        word_tag = 16'h0600;
        run_xfer(4'h7, 16'h0003, 1, 0, 1, 0, 0, 0, 1'b0, b, dn, er, wd, cm);
        chk(dn == 1 && er == 0, "R8", "zero limit immediate ack", dn, 1);
        word_tag = 16'h0700;
        run_xfer(4'h7, 16'h0004, 1, 1, 1, 0, 0, 0, 1'b0, b, dn, er, wd, cm);
        chk(er == 1 && dn == 0 && b == 3, "R8", "zero limit late ack", b, 3);
        tmo_limit = 16'd8;

        // R9: a new request is accepted after an error
        word_tag = 16'h0800;
        run_xfer(4'h9, 16'h0005, 1, 0, 1, 0, 0, 0, 1'b0, b, dn, er, wd, cm);
        chk(dn == 1 && wd == 1 && b == 4, "R9", "recovery after error", b, 4);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule